// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block is a small direct-mapped branch target buffer that the fetch stage consults every cycle with the PC it is about to fetch. The lookup is purely combinational. When the PC's entry is valid and its tag matches, the block reports a hit and the stored target. The block also offers that target as the next fetch address, because every branch found in the table is assumed taken. On a miss the next fetch address is the sequential one, two bytes on, since instructions are 16-bit and word aligned.

Later in the pipeline a branch resolves. The stage that resolves it presents four things:

- the branch PC;
- the actual direction;
- the computed target;
- the prediction that fetch made for that branch: whether it hit, and what target it gave.

From these the block raises a mispredict flag for the flush logic outside it. A taken branch writes its PC tag and target into the slot selected by its PC and replaces whatever was there. A not-taken branch leaves the table alone. A write becomes visible to lookups on the cycle after it is presented, so a lookup that shares a cycle with a write still sees the old slot contents.

Top module: `btb_predictor`

## Requirements
- R1: While `rst` is high at a rising edge, every slot is invalidated. After reset, no fetch PC hits until a taken branch has been written.
- R2: The slot index is PC bits [4:1] and the tag is PC bits [15:5]. PC bit 0 has no part in either, so two PCs that differ only in bit 0 share a slot and a tag.
- R3: A hit needs a valid slot whose stored tag equals the fetch PC's tag. A PC that shares a slot with a stored branch but has a different tag misses.
- R4: On a hit, `pred_hit` is 1, `pred_target` is the stored target, and `next_pc` equals that target (predicted taken).
- R5: On a miss, `pred_hit` is 0, `pred_target` is 0, and `next_pc` is `fetch_pc + 2`.
- R6: A resolution with `res_valid=1` and `res_taken=1` writes valid, the tag of `res_pc` and `res_target` into the slot of `res_pc` at the rising edge. The write replaces any earlier branch that held that slot, and that earlier branch then misses.
- R7: A resolution with `res_taken=0` changes no slot: a branch stored beforehand still hits with its old target.
- R8: A lookup in the same cycle as a write to the same slot returns the slot's old contents. The new contents are returned from the next cycle.
- R9: `mispredict` is 1 when `res_valid=1`, `res_pred_hit=1` and `res_taken=0`.
- R10: `mispredict` is 1 when `res_valid=1`, `res_pred_hit=1`, `res_taken=1` and `res_target` differs from `res_pred_target`. It is 0 when the two targets are equal.
- R11: `mispredict` is 1 when `res_valid=1`, `res_pred_hit=0` and `res_taken=1`. It is 0 for a missed not-taken branch and whenever `res_valid=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 16 | PC being fetched this cycle |
| pred_hit | output | 1 | Fetch PC found in the table |
| pred_target | output | 16 | Stored target on a hit, 0 on a miss |
| next_pc | output | 16 | Predicted next fetch address |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 16 | PC of the resolving branch |
| res_taken | input | 1 | Actual direction of the resolving branch |
| res_target | input | 16 | Computed target of the resolving branch |
| res_pred_hit | input | 1 | Hit flag recorded at fetch for this branch |
| res_pred_target | input | 16 | Target predicted at fetch for this branch |
| mispredict | output | 1 | Resolved outcome disagrees with the fetch prediction |

## Verification
The bench aims at slot aliasing. Two branches whose PCs share bits [4:1] must evict one another, and a design that compared too few tag bits would report a false hit for the second PC with the first one's target. It checks that PC bit 0 is ignored and that a not-taken resolution leaves a stored entry intact. A design that wrote every resolution would lose the entry and miss afterwards. It presents a lookup and a write to the same slot in one cycle: a design that forwarded the write would return the new target a cycle early. The remaining checks cover each mispredict case separately: wrong direction, wrong target, a taken miss, and the quiet cases, where a swapped or missing term would raise or drop the flag.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int PC_W       = 16;
    localparam int ENTRIES    = 16;
    localparam int INST_BYTES = 2;
    localparam int OFS_W      = $clog2(INST_BYTES);
    localparam int IDX_W      = $clog2(ENTRIES);
    localparam int TAG_W      = PC_W - IDX_W - OFS_W;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;

    // One slot of the table
    typedef struct packed {
        logic valid;
        tag_t tag;
        pc_t  target;
    } btb_entry_t;

    // Write request from the resolution side
    typedef struct packed {
        logic en;
        idx_t idx;
        tag_t tag;
        pc_t  target;
    } btb_write_t;

    // Classification of a resolving branch against its fetch prediction
    typedef enum logic [2:0] {
        RES_IDLE,
        RES_CORRECT,
        RES_WRONG_DIR,
        RES_WRONG_TGT,
        RES_MISSED_TAKEN
    } res_class_t;

    function automatic idx_t idx_of(pc_t pc);
        return pc[OFS_W +: IDX_W];
    endfunction

    function automatic tag_t tag_of(pc_t pc);
        return pc[PC_W-1 -: TAG_W];
    endfunction

    function automatic logic is_wrong(res_class_t c);
        return (c == RES_WRONG_DIR) || (c == RES_WRONG_TGT) || (c == RES_MISSED_TAKEN);
    endfunction

endpackage

// File: rtl/btb_table.sv
module btb_table
    import btb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  btb_write_t wr,
    input  idx_t       rd_idx,
    output btb_entry_t rd_entry
);

    btb_entry_t slots [ENTRIES];
    logic [ENTRIES-1:0] valid_vec;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (wr.en && (wr.idx == idx_t'(i))) begin
                slots[i].valid  <= 1'b1;
                slots[i].tag    <= wr.tag;
                slots[i].target <= wr.target;
            end
        end
        assign valid_vec[i] = slots[i].valid;
    end

    // Read returns registered contents: a same-cycle write is not forwarded
    assign rd_entry = slots[rd_idx];

    // R7: without a write request no slot's valid bit moves
    p_hold_without_write_r7: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(valid_vec));

    // R6: a requested write leaves its slot valid on the following cycle
    p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> valid_vec[$past(wr.idx)]);

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
(
    input  pc_t        fetch_pc,
    input  btb_entry_t entry,
    output idx_t       rd_idx,
    output logic       hit,
    output pc_t        target,
    output pc_t        next_pc
);

    pc_t seq_pc;

    assign rd_idx = idx_of(fetch_pc);
    assign seq_pc = fetch_pc + pc_t'(INST_BYTES);

    always_comb begin
        hit     = entry.valid && (entry.tag == tag_of(fetch_pc));
        target  = hit ? entry.target : '0;
        next_pc = hit ? entry.target : seq_pc;
    end

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
    import btb_pkg::*;
(
    input  logic       res_valid,
    input  pc_t        res_pc,
    input  logic       res_taken,
    input  pc_t        res_target,
    input  logic       res_pred_hit,
    input  pc_t        res_pred_target,
    output btb_write_t wr,
    output res_class_t res_class,
    output logic       mispredict
);

    always_comb begin
        if (!res_valid)
            res_class = RES_IDLE;
        else if (res_pred_hit && !res_taken)
            res_class = RES_WRONG_DIR;
        else if (res_pred_hit && (res_target != res_pred_target))
            res_class = RES_WRONG_TGT;
        else if (!res_pred_hit && res_taken)
            res_class = RES_MISSED_TAKEN;
        else
            res_class = RES_CORRECT;
    end

    assign mispredict = is_wrong(res_class);

    // Only taken branches allocate; not-taken outcomes leave the table alone
    always_comb begin
        wr.en     = res_valid && res_taken;
        wr.idx    = idx_of(res_pc);
        wr.tag    = tag_of(res_pc);
        wr.target = res_target;
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] fetch_pc,
    output logic        pred_hit,
    output logic [15:0] pred_target,
    output logic [15:0] next_pc,
    input  logic        res_valid,
    input  logic [15:0] res_pc,
    input  logic        res_taken,
    input  logic [15:0] res_target,
    input  logic        res_pred_hit,
    input  logic [15:0] res_pred_target,
    output logic        mispredict
);

    btb_write_t wr;
    btb_entry_t rd_entry;
    idx_t       rd_idx;
    res_class_t res_class;

    btb_table u_table (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry)
    );

    btb_lookup u_lookup (
        .fetch_pc (fetch_pc),
        .entry    (rd_entry),
        .rd_idx   (rd_idx),
        .hit      (pred_hit),
        .target   (pred_target),
        .next_pc  (next_pc)
    );

    btb_resolve u_resolve (
        .res_valid       (res_valid),
        .res_pc          (res_pc),
        .res_taken       (res_taken),
        .res_target      (res_target),
        .res_pred_hit    (res_pred_hit),
        .res_pred_target (res_pred_target),
        .wr              (wr),
        .res_class       (res_class),
        .mispredict      (mispredict)
    );

    // R1: the cycle after a reset edge nothing hits
    p_reset_empty_r1: assert property (@(posedge clk)
        $past(rst) |-> !pred_hit);

    // R6, R8: a taken branch is found with its target on the next cycle
    p_fill_visible_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_taken) ##1 (fetch_pc[15:1] == $past(res_pc[15:1]))
        |-> (pred_hit && pred_target == $past(res_target)));

    // R4: a hit steers fetch to the stored target
    p_hit_redirect_r4: assert property (@(posedge clk) disable iff (rst)
        pred_hit |-> (next_pc == pred_target));

    // R5: a miss falls through to the next word
    p_miss_sequential_r5: assert property (@(posedge clk) disable iff (rst)
        !pred_hit |-> (next_pc == fetch_pc + 16'd2));

    // R9: a hit that resolves not taken is flagged
    p_wrong_dir_r9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_pred_hit && !res_taken) |-> mispredict);

    // R11: no resolution, no flag; a taken miss is flagged
    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !mispredict);
    p_taken_miss_r11: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_pred_hit && res_taken) |-> mispredict);

    // R10: a hit confirmed taken with matching target is not flagged
    p_target_match_r10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_pred_hit && res_taken && res_target == res_pred_target)
        |-> !mispredict);

endmodule

// File: tb/btb_predictor_bench.sv
module btb_predictor_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] fetch_pc;
    logic        pred_hit;
    logic [15:0] pred_target;
    logic [15:0] next_pc;
    logic        res_valid;
    logic [15:0] res_pc;
    logic        res_taken;
    logic [15:0] res_target;
    logic        res_pred_hit;
    logic [15:0] res_pred_target;
    logic        mispredict;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    btb_predictor u_btb_predictor (
        .clk             (clk),
        .rst             (rst),
        .fetch_pc        (fetch_pc),
        .pred_hit        (pred_hit),
        .pred_target     (pred_target),
        .next_pc         (next_pc),
        .res_valid       (res_valid),
        .res_pc          (res_pc),
        .res_taken       (res_taken),
        .res_target      (res_target),
        .res_pred_hit    (res_pred_hit),
        .res_pred_target (res_pred_target),
        .mispredict      (mispredict)
    );

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
        end
    endtask

    // Drive a fetch PC and check the combinational result
    task automatic expect_lookup(string req, logic [15:0] pc, logic hit, logic [15:0] tgt);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        check(req, "pred_hit", 16'(pred_hit), 16'(hit));
        check(req, "pred_target", pred_target, hit ? tgt : 16'h0000);
        check(req, "next_pc", next_pc, hit ? tgt : pc + 16'd2);
    endtask

    // Present one resolution across a rising edge
    task automatic resolve(logic [15:0] pc, logic taken, logic [15:0] tgt);
        @(negedge clk);
        res_valid       = 1'b1;
        res_pc          = pc;
        res_taken       = taken;
        res_target      = tgt;
        res_pred_hit    = 1'b0;
        res_pred_target = 16'h0000;
        @(negedge clk);
        res_valid = 1'b0;
        res_taken = 1'b0;
    endtask

    task automatic expect_flag(string req, logic ph, logic [15:0] pt, logic v,
                               logic tk, logic [15:0] tg, logic exp);
        @(negedge clk);
        res_valid       = v;
        res_pc          = 16'h0F00;
        res_taken       = tk;
        res_target      = tg;
        res_pred_hit    = ph;
        res_pred_target = pt;
        #1;
        check(req, "mispredict", 16'(mispredict), 16'(exp));
        @(negedge clk);
        res_valid = 1'b0;
        res_taken = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        expect_lookup("R1", 16'h0000, 1'b0, 16'h0);
        expect_lookup("R1", 16'h0104, 1'b0, 16'h0);
        check("R1", "mispredict idle", 16'(mispredict), 16'h0);
    endtask

    task automatic t_miss_path;
        expect_lookup("R5", 16'h1230, 1'b0, 16'h0);
        expect_lookup("R5", 16'hFFFE, 1'b0, 16'h0);
    endtask

    task automatic t_fill_hit;
        resolve(16'h0104, 1'b1, 16'h0400);
        expect_lookup("R4", 16'h0104, 1'b1, 16'h0400);
        expect_lookup("R6", 16'h0106, 1'b0, 16'h0);
    endtask

    task automatic t_bit0;
        expect_lookup("R2", 16'h0105, 1'b1, 16'h0400);
    endtask

    task automatic t_alias;
        // 0x0204 shares bits [4:1] with 0x0104 but not bits [15:5]
        expect_lookup("R3", 16'h0204, 1'b0, 16'h0);
        resolve(16'h0204, 1'b1, 16'h0800);
        expect_lookup("R6", 16'h0204, 1'b1, 16'h0800);
        expect_lookup("R6", 16'h0104, 1'b0, 16'h0);
    endtask

    task automatic t_not_taken;
        resolve(16'h0204, 1'b0, 16'h0AAA);
        expect_lookup("R7", 16'h0204, 1'b1, 16'h0800);
        resolve(16'h0340, 1'b0, 16'h0555);
        expect_lookup("R7", 16'h0340, 1'b0, 16'h0);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        fetch_pc        = 16'h0204;
        res_valid       = 1'b1;
        res_pc          = 16'h0204;
        res_taken       = 1'b1;
        res_target      = 16'h0C00;
        res_pred_hit    = 1'b1;
        res_pred_target = 16'h0800;
        #1;
        check("R8", "old target same cycle", pred_target, 16'h0800);
        @(negedge clk);
        res_valid = 1'b0;
        #1;
        check("R8", "new target next cycle", pred_target, 16'h0C00);
    endtask

    task automatic t_mispredict;
        expect_flag("R9",  1'b1, 16'h0400, 1'b1, 1'b0, 16'h0400, 1'b1);
        expect_flag("R10", 1'b1, 16'h0400, 1'b1, 1'b1, 16'h0402, 1'b1);
        expect_flag("R10", 1'b1, 16'h0400, 1'b1, 1'b1, 16'h0400, 1'b0);
        expect_flag("R11", 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0400, 1'b1);
        expect_flag("R11", 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0400, 1'b0);
        expect_flag("R11", 1'b1, 16'h0400, 1'b0, 1'b0, 16'h0400, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst             = 1'b1;
        fetch_pc        = 16'h0000;
        res_valid       = 1'b0;
        res_pc          = 16'h0000;
        res_taken       = 1'b0;
        res_target      = 16'h0000;
        res_pred_hit    = 1'b0;
        res_pred_target = 16'h0000;
        t_reset();
        t_miss_path();
        t_fill_hit();
        t_bit0();
        t_alias();
        t_not_taken();
        t_same_cycle();
        t_mispredict();
        t_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule